// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt events from a set of functional units and folds them into one level-sensitive interrupt request line. Each unit has a local register pair: a status register with one sticky bit per event source, and an enable register that chooses which of those sources reach the top level. At the top level, each unit appears as a single read-only flag bit. A software-owned bit sits at bit 31 of the same register, so firmware can raise an interrupt on itself.

A top-level enable register selects which unit flags and whether the software bit can become pending. A two-bit global control register then gates the two kinds of pending interrupt separately. Bit 0 passes unit (component) interrupts and bit 1 passes the software interrupt. The request output is registered. Software reaches all registers through a flat 32-bit port: a write strobe with address and data, and a read data bus that is decoded combinationally from the address.

Top module: `intr_agg`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A one-cycle pulse on a source's `evt` bit sets that source's local status bit on the next edge. The bit stays set whatever the local enable holds. Unit u, source b is `evt[u*SRC_W+b]`.
- R3: A write to a unit's status register (address 0x40+8u) clears the bits written as 1 and leaves the bits written as 0. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Bit u of the top status register (address 0x00) reads as the OR of unit u's status bits ANDed with its enable bits (address 0x44+8u). Writes to the unit bits of the top status register have no effect.
- R5: Bit 31 of the top status register is the software interrupt. A write to address 0x00 loads it from wdata bit 31.
- R6: `irq` in a cycle equals the gated pending condition of the previous cycle. It therefore falls one cycle after the last pending source is cleared.
- R7: Global control (address 0x08) bit 0 gates only unit interrupts and bit 1 gates only the software interrupt. With both bits clear, `irq` stays 0.
- R8: Top enable (address 0x04) bit u gates unit u's flag and bit 31 gates the software bit. A flag whose enable is clear raises no interrupt.
- R9: Reads of an undecoded address return 0. Writes to an undecoded address change no register.
- R10: Unimplemented bits read as 0. Top enable keeps only bits 31 and [NUM_UNITS-1:0], control keeps bits [1:0], and local registers keep bits [SRC_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | NUM_UNITS*SRC_W | One-cycle event pulses; unit u, source b at bit u*SRC_W+b |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Registered level interrupt request |

## Verification
The bench goes after the case where an event and a write-1-to-clear reach the same bit in the same cycle. A design that lets the clear win would silently drop an interrupt. It writes ones to the read-only unit bits of the top status register; a design that stored them would raise interrupts no unit asked for. It toggles each global control bit on its own with both a unit flag and the software bit pending. A design that crossed the two gates, or that shares one gate between them, would assert `irq` when it should not or miss it. It also times the fall of `irq` after the final clear. An unregistered or doubly registered output would shift that edge by one cycle.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
    localparam int REG_ADDR_W  = 8;
    localparam int REG_DATA_W  = 32;
    localparam int SWI_BIT     = REG_DATA_W - 1;
    localparam int CTRL_W      = 2;
    localparam int CTRL_COMP   = 0;
    localparam int CTRL_SWI    = 1;

    localparam logic [REG_ADDR_W-1:0] A_TOP_STAT = 8'h00;
    localparam logic [REG_ADDR_W-1:0] A_TOP_EN   = 8'h04;
    localparam logic [REG_ADDR_W-1:0] A_CTRL     = 8'h08;
    localparam int UNIT_BASE   = 8'h40;
    localparam int UNIT_STRIDE = 8;
    localparam int UNIT_EN_OFS = 4;

    function automatic logic [REG_ADDR_W-1:0] unit_stat_addr(input int u);
        return REG_ADDR_W'(UNIT_BASE + u * UNIT_STRIDE);
    endfunction

    function automatic logic [REG_ADDR_W-1:0] unit_en_addr(input int u);
        return REG_ADDR_W'(UNIT_BASE + u * UNIT_STRIDE + UNIT_EN_OFS);
    endfunction
endpackage

// File: rtl/intr_unit_regs.sv
module intr_unit_regs
    import intr_agg_pkg::*;
#(
    parameter int SRC_W = 8,
    parameter int IDX   = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRC_W-1:0]      evt,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]      wdata,
    output logic [SRC_W-1:0]      stat,
    output logic [SRC_W-1:0]      mask,
    output logic                  flag
);
    localparam logic [REG_ADDR_W-1:0] MY_STAT = unit_stat_addr(IDX);
    localparam logic [REG_ADDR_W-1:0] MY_EN   = unit_en_addr(IDX);

    typedef struct packed {
        logic [SRC_W-1:0] stat;
        logic [SRC_W-1:0] mask;
    } unit_state_t;

    unit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == MY_STAT) begin
            st_d.stat = st_q.stat & ~wdata;
        end
        if (wr_en && addr == MY_EN) begin
            st_d.mask = wdata;
        end
        st_d.stat = st_d.stat | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign mask = st_q.mask;
    assign flag = |(st_q.stat & st_q.mask);
endmodule

// File: rtl/intr_top_regs.sv
module intr_top_regs
    import intr_agg_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  wdata_swi,
    input  logic [NUM_UNITS-1:0]  wdata_units,
    input  logic [CTRL_W-1:0]     wdata_ctrl,
    output logic                  swi,
    output logic                  swi_en,
    output logic [NUM_UNITS-1:0]  unit_en,
    output logic [CTRL_W-1:0]     ctrl
);
    typedef struct packed {
        logic                 swi;
        logic                 swi_en;
        logic [NUM_UNITS-1:0] unit_en;
        logic [CTRL_W-1:0]    ctrl;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                A_TOP_STAT: st_d.swi = wdata_swi;
                A_TOP_EN: begin
                    st_d.swi_en  = wdata_swi;
                    st_d.unit_en = wdata_units;
                end
                A_CTRL:  st_d.ctrl = wdata_ctrl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign swi     = st_q.swi;
    assign swi_en  = st_q.swi_en;
    assign unit_en = st_q.unit_en;
    assign ctrl    = st_q.ctrl;
endmodule

// File: rtl/intr_req_gen.sv
module intr_req_gen
    import intr_agg_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] unit_flag,
    input  logic [NUM_UNITS-1:0] unit_en,
    input  logic                 swi,
    input  logic                 swi_en,
    input  logic [CTRL_W-1:0]    ctrl,
    output logic                 irq
);
    typedef struct packed {
        logic irq;
    } req_state_t;

    req_state_t st_d, st_q;
    logic comp_pend;
    logic swi_pend;

    always_comb begin
        comp_pend = |(unit_flag & unit_en);
        swi_pend  = swi & swi_en;
        st_d.irq  = (ctrl[CTRL_COMP] & comp_pend) | (ctrl[CTRL_SWI] & swi_pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/intr_rd_mux.sv
module intr_rd_mux
    import intr_agg_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int SRC_W     = 8
) (
    input  logic [REG_ADDR_W-1:0]      addr,
    input  logic [NUM_UNITS*SRC_W-1:0] stat_all,
    input  logic [NUM_UNITS*SRC_W-1:0] mask_all,
    input  logic [NUM_UNITS-1:0]       unit_flag,
    input  logic [NUM_UNITS-1:0]       unit_en,
    input  logic                       swi,
    input  logic                       swi_en,
    input  logic [CTRL_W-1:0]          ctrl,
    output logic [REG_DATA_W-1:0]      rdata
);
    always_comb begin
        rdata = '0;
        if (addr == A_TOP_STAT) begin
            rdata[SWI_BIT]         = swi;
            rdata[NUM_UNITS-1:0]   = unit_flag;
        end
        if (addr == A_TOP_EN) begin
            rdata[SWI_BIT]         = swi_en;
            rdata[NUM_UNITS-1:0]   = unit_en;
        end
        if (addr == A_CTRL) begin
            rdata[CTRL_W-1:0]      = ctrl;
        end
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (addr == unit_stat_addr(u)) begin
                rdata[SRC_W-1:0] = stat_all[u*SRC_W +: SRC_W];
            end
            if (addr == unit_en_addr(u)) begin
                rdata[SRC_W-1:0] = mask_all[u*SRC_W +: SRC_W];
            end
        end
    end
endmodule

// File: rtl/intr_agg.sv
module intr_agg
    import intr_agg_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int SRC_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_UNITS*SRC_W-1:0] evt,
    input  logic                       wr_en,
    input  logic [REG_ADDR_W-1:0]      addr,
    input  logic [REG_DATA_W-1:0]      wdata,
    output logic [REG_DATA_W-1:0]      rdata,
    output logic                       irq
);
    localparam int TOTAL_SRC = NUM_UNITS * SRC_W;

    logic [TOTAL_SRC-1:0] stat_all;
    logic [TOTAL_SRC-1:0] mask_all;
    logic [NUM_UNITS-1:0] unit_flag;
    logic [NUM_UNITS-1:0] unit_en;
    logic                 swi;
    logic                 swi_en;
    logic [CTRL_W-1:0]    ctrl;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        intr_unit_regs #(
            .SRC_W (SRC_W),
            .IDX   (u)
        ) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt[u*SRC_W +: SRC_W]),
            .wr_en (wr_en),
            .addr  (addr),
            .wdata (wdata[SRC_W-1:0]),
            .stat  (stat_all[u*SRC_W +: SRC_W]),
            .mask  (mask_all[u*SRC_W +: SRC_W]),
            .flag  (unit_flag[u])
        );
    end

    intr_top_regs #(
        .NUM_UNITS (NUM_UNITS)
    ) u_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata_swi   (wdata[SWI_BIT]),
        .wdata_units (wdata[NUM_UNITS-1:0]),
        .wdata_ctrl  (wdata[CTRL_W-1:0]),
        .swi         (swi),
        .swi_en      (swi_en),
        .unit_en     (unit_en),
        .ctrl        (ctrl)
    );

    intr_req_gen #(
        .NUM_UNITS (NUM_UNITS)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_flag (unit_flag),
        .unit_en   (unit_en),
        .swi       (swi),
        .swi_en    (swi_en),
        .ctrl      (ctrl),
        .irq       (irq)
    );

    intr_rd_mux #(
        .NUM_UNITS (NUM_UNITS),
        .SRC_W     (SRC_W)
    ) u_rd (
        .addr      (addr),
        .stat_all  (stat_all),
        .mask_all  (mask_all),
        .unit_flag (unit_flag),
        .unit_en   (unit_en),
        .swi       (swi),
        .swi_en    (swi_en),
        .ctrl      (ctrl),
        .rdata     (rdata)
    );
endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk
    import intr_agg_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int SRC_W     = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_UNITS*SRC_W-1:0] evt,
    input logic                       wr_en,
    input logic [REG_ADDR_W-1:0]      addr,
    input logic [REG_DATA_W-1:0]      wdata,
    input logic                       irq,
    input logic [NUM_UNITS*SRC_W-1:0] stat_all,
    input logic [NUM_UNITS-1:0]       unit_flag,
    input logic [NUM_UNITS-1:0]       unit_en,
    input logic                       swi,
    input logic                       swi_en,
    input logic [CTRL_W-1:0]          ctrl
);
    logic comp_live;
    logic swi_live;
    logic seen_edge;

    assign comp_live = ctrl[CTRL_COMP] && ((unit_flag & unit_en) != '0);
    assign swi_live  = ctrl[CTRL_SWI] && swi && swi_en;

    initial seen_edge = 1'b0;
    always @(posedge clk) seen_edge <= 1'b1;

    // R1
    always @(negedge clk) begin
        if (seen_edge && !rst_n) begin
            reset_quiet_chk: assert (irq == 1'b0);
        end
    end

    // R2
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_all & $past(evt)) == $past(evt)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == unit_stat_addr(0) && wdata[SRC_W-1:0] == '1
         && evt[SRC_W-1:0] == '0) |=> (stat_all[SRC_W-1:0] == '0));

    // R5
    swi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TOP_STAT) |=> (swi == $past(wdata[SWI_BIT])));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_live || swi_live) |=> irq);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(comp_live || swi_live) |=> !irq);

    // R7
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |=> !irq);
endmodule

bind intr_agg intr_agg_chk #(
    .NUM_UNITS (NUM_UNITS),
    .SRC_W     (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .stat_all  (stat_all),
    .unit_flag (unit_flag),
    .unit_en   (unit_en),
    .swi       (swi),
    .swi_en    (swi_en),
    .ctrl      (ctrl)
);

// File: tb/intr_agg_tb.sv
module intr_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 4;
    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NU*SW-1:0] evt = '0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    logic [SW-1:0] m_ls [NU];
    logic [SW-1:0] m_le [NU];
    logic [NU-1:0] m_ten;
    logic          m_tsw;
    logic          m_sw;
    logic [1:0]    m_ctrl;
    logic          m_irq;

    int n_chk = 0;
    int n_fail = 0;

    intr_agg #(.NUM_UNITS(NU), .SRC_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) begin
            r[31] = m_sw;
            for (int u = 0; u < NU; u++) r[u] = |(m_ls[u] & m_le[u]);
        end else if (a == 8'h04) begin
            r[31] = m_tsw;
            r[NU-1:0] = m_ten;
        end else if (a == 8'h08) begin
            r[1:0] = m_ctrl;
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (a == 8'(8'h40 + 8*u)) r[SW-1:0] = m_ls[u];
                if (a == 8'(8'h44 + 8*u)) r[SW-1:0] = m_le[u];
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_ls[u] = '0;
            m_le[u] = '0;
        end
        m_ten = '0; m_tsw = 0; m_sw = 0; m_ctrl = '0; m_irq = 0;
    endtask

    // One clock: drive, check readback, advance the model, check irq.
    task automatic step(input logic [NU*SW-1:0] e, input logic w,
                        input logic [7:0] a, input logic [31:0] d);
        logic [SW-1:0] nls [NU];
        logic [SW-1:0] nle [NU];
        logic comp;
        logic nirq;
        evt = e; wr_en = w; addr = a; wdata = d;
        #1;
        chk("R10/R4 readback", rdata, m_read(a));
        comp = 0;
        for (int u = 0; u < NU; u++) begin
            if ((|(m_ls[u] & m_le[u])) && m_ten[u]) comp = 1;
            nls[u] = m_ls[u];
            nle[u] = m_le[u];
            if (w && a == 8'(8'h40 + 8*u)) nls[u] = nls[u] & ~d[SW-1:0];
            if (w && a == 8'(8'h44 + 8*u)) nle[u] = d[SW-1:0];
            nls[u] = nls[u] | e[u*SW +: SW];
        end
        nirq = (m_ctrl[0] && comp) || (m_ctrl[1] && m_sw && m_tsw);
        @(posedge clk);
        for (int u = 0; u < NU; u++) begin
            m_ls[u] = nls[u];
            m_le[u] = nle[u];
        end
        if (w && a == 8'h00) m_sw = d[31];
        if (w && a == 8'h04) begin m_tsw = d[31]; m_ten = d[NU-1:0]; end
        if (w && a == 8'h08) m_ctrl = d[1:0];
        m_irq = nirq;
        @(negedge clk);
        chk("R6 irq vs model", {31'b0, irq}, {31'b0, m_irq});
        evt = '0; wr_en = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a; wr_en = 0; evt = '0;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic idle();
        step('0, 0, 8'h00, 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rd("R1 top status", 8'h00, 32'h0);
        rd("R1 top enable", 8'h04, 32'h0);
        rd("R1 control", 8'h08, 32'h0);
        rd("R1 unit2 enable", 8'h54, 32'h0);

        // R2: event latches even with local enable clear
        step(32'h0000_0008, 0, 8'h00, 0);
        rd("R2 unit0 status latched", 8'h40, 32'h08);
        rd("R4 flag needs local enable", 8'h00, 32'h0);

        step('0, 1, 8'h44, 32'h08);
        rd("R4 flag with local enable", 8'h00, 32'h1);
        idle();
        chk("R8 top enable clear", {31'b0, irq}, 32'h0);

        step('0, 1, 8'h04, 32'h1);
        idle();
        chk("R7 control zero", {31'b0, irq}, 32'h0);
        step('0, 1, 8'h08, 32'h1);
        idle();
        chk("R6 irq asserted", {31'b0, irq}, 32'h1);

        // R4: unit bits at top are read-only
        step('0, 1, 8'h00, 32'h0000_000F);
        rd("R4 unit bits read-only", 8'h00, 32'h1);

        // R3: write-one-to-clear
        step('0, 1, 8'h40, 32'h01);
        rd("R3 zero bits untouched", 8'h40, 32'h08);
        step('0, 1, 8'h40, 32'h08);
        rd("R3 cleared", 8'h40, 32'h00);
        chk("R6 irq still high one cycle", {31'b0, irq}, 32'h1);
        idle();
        chk("R6 irq falls after clear", {31'b0, irq}, 32'h0);

        step(32'h0000_0008, 1, 8'h40, 32'h08);
        rd("R3 event beats clear", 8'h40, 32'h08);
        step('0, 1, 8'h40, 32'hFF);
        idle();

        // R5 / R7 / R8: software interrupt
        step('0, 1, 8'h00, 32'h8000_0000);
        rd("R5 software bit set", 8'h00, 32'h8000_0000);
        idle();
        chk("R8 software not enabled", {31'b0, irq}, 32'h0);
        step('0, 1, 8'h04, 32'h8000_0001);
        idle();
        chk("R7 comp gate blocks software", {31'b0, irq}, 32'h0);
        step('0, 1, 8'h08, 32'h2);
        idle();
        chk("R7 software gate passes", {31'b0, irq}, 32'h1);
        step(32'h0000_0008, 0, 8'h00, 0);
        step('0, 1, 8'h00, 32'h0);
        idle();
        chk("R7 software gate blocks unit", {31'b0, irq}, 32'h0);
        rd("R5 software bit cleared", 8'h00, 32'h1);

        // R9: undecoded addresses
        step('0, 1, 8'h3C, 32'hFFFF_FFFF);
        step('0, 1, 8'h0C, 32'hFFFF_FFFF);
        rd("R9 undecoded reads zero", 8'h3C, 32'h0);
        rd("R9 enable unchanged", 8'h04, 32'h8000_0001);
        rd("R9 control unchanged", 8'h08, 32'h2);
        rd("R9 unit0 enable unchanged", 8'h44, 32'h08);

        // R10: masking of unimplemented bits
        step('0, 1, 8'h04, 32'hFFFF_FFFF);
        rd("R10 top enable width", 8'h04, 32'h8000_000F);
        step('0, 1, 8'h08, 32'hFFFF_FFFF);
        rd("R10 control width", 8'h08, 32'h3);
        step('0, 1, 8'h5C, 32'hFFFF_FFFF);
        rd("R10 unit3 enable width", 8'h5C, 32'hFF);

        // R2/R6 multiple units
        step(32'h8000_0000, 0, 8'h00, 0);
        idle();
        chk("R6 unit3 irq", {31'b0, irq}, 32'h1);
        rd("R2 unit3 status", 8'h58, 32'h80);

        // Mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            logic [NU*SW-1:0] e;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:0])
                4'd0: a = 8'h00;
                4'd1: a = 8'h04;
                4'd2: a = 8'h08;
                4'd3: a = 8'h30;
                default: a = 8'(8'h40 + 4*(lfsr[6:4]));
            endcase
            d = {lfsr, lfsr ^ 16'h5A5A};
            e = (lfsr[9:7] == 3'd0) ? (32'h1 << lfsr[15:11]) : '0;
            step(e, lfsr[10], a, d);
        end

        finish_run();
    end
endmodule